// File: doc/BRIEF.md
# Modular Product Lookup Encoder

This block multiplies two residues of one fixed modulus and returns their product reduced by that modulus. It does no arithmetic at run time. A table holds every product, and the operands only select an entry. The table is filled in at elaboration from the modulus parameter alone. The same instance therefore serves any coefficient set and any data stream in a residue-domain filter channel of that modulus, and changing coefficients never touches the encoder.

Multiplication commutes, so the table keeps one entry per unordered pair. The operands are first sorted: the smaller becomes the column and the larger the row. A triangular index, row·(row+1)/2 + column, then picks the entry. The table has MODULUS·(MODULUS+1)/2 entries where a full square table would have MODULUS². A parameter chooses the variant. One variant registers the result behind a clock enable, with one cycle of latency. The other is purely combinational.

Top module: `modprod_lut`

## Requirements
- R1: With operands a_i, b_i in 0..MODULUS-1, the result is (a_i·b_i) mod MODULUS for every pair; the default MODULUS is 33 with 6-bit operands and result.
- R2: Swapping the two operands never changes the result.
- R3: With OUT_REG=1, operands sampled at a rising clock edge with en high appear on p_o after that edge, and p_o keeps its old value until then.
- R4: With OUT_REG=1 and en low at a rising edge, p_o keeps its value whatever the operands are.
- R5: While rst_n is low, p_o is 0 in the registered variant, and it is 0 as soon as rst_n falls, without waiting for a clock edge.
- R6: An operand of 0 gives 0, and (MODULUS-1)·(MODULUS-1) gives 1.
- R7: p_o never reaches MODULUS or above, and operands of MODULUS or above are flagged as outside the contract.
- R8: With OUT_REG=0 the result follows the operands in the same cycle. This holds for other moduli too: for modulus 8, 6·2 gives 4 and 4·2 gives 0; for modulus 9, 7·8 gives 2 and 6·8 gives 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable of the result register |
| a_i | input | $clog2(MODULUS) | First residue operand |
| b_i | input | $clog2(MODULUS) | Second residue operand |
| p_o | output | $clog2(MODULUS) | Residue product |

## Verification
The hardest case to reach is the folding itself: the mirrored half of the operand square, where the larger operand arrives on a_i, must read the same entry as its counterpart. Wrong sorting shows up only for some pairs and some moduli. The stimulus therefore sweeps the full operand square of the default modulus and checks each mirrored pair against the other. It also sweeps a power-of-two modulus and a small odd modulus in combinational instances. Seeded random pairs with random enable gaps then exercise the hold behaviour between loads.

// File: rtl/modprod_pkg.sv
`timescale 1ns/1ps
package modprod_pkg;

  // first entry of row r in the folded table
  function automatic int tri_base(input int r);
    return (r * (r + 1)) / 2;
  endfunction

  // number of folded entries for a modulus
  function automatic int tri_entries(input int m);
    return (m * (m + 1)) / 2;
  endfunction

  // stored product for a row/column pair
  function automatic int mod_product(input int r, input int c, input int m);
    return (r * c) % m;
  endfunction

endpackage

// File: rtl/modprod_order.sv
`timescale 1ns/1ps
// Sorts the two operands so the smaller one becomes the column index.
module modprod_order #(
  parameter int W = 6
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  logic swap;

  always_comb begin
    swap = (y_i < x_i);
    lo_o = swap ? y_i : x_i;
    hi_o = swap ? x_i : y_i;
  end
endmodule

// File: rtl/modprod_tri_idx.sv
`timescale 1ns/1ps
// Forms hi*(hi+1)/2 + lo in a width wide enough for any W-bit operands.
module modprod_tri_idx #(
  parameter int W  = 6,
  parameter int XW = 2 * W + 1
) (
  input  logic [W-1:0]  lo_i,
  input  logic [W-1:0]  hi_i,
  output logic [XW-1:0] idx_o
);
  logic [XW-1:0] hi_x;
  logic [XW-1:0] lo_x;
  logic [XW-1:0] row_base;

  always_comb begin
    hi_x     = XW'(hi_i);
    lo_x     = XW'(lo_i);
    row_base = (hi_x * (hi_x + XW'(1))) >> 1;
    idx_o    = row_base + lo_x;
  end
endmodule

// File: rtl/modprod_rom.sv
`timescale 1ns/1ps
// Folded product table, filled at elaboration from the modulus.
module modprod_rom
  import modprod_pkg::*;
#(
  parameter int MODULUS = 33,
  parameter int W       = $clog2(MODULUS),
  parameter int XW      = 2 * W + 1
) (
  input  logic [XW-1:0] idx_i,
  output logic [W-1:0]  prod_o
);
  localparam int ENTRIES = tri_entries(MODULUS);
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [W-1:0] tbl [ENTRIES];

  for (genvar r = 0; r < MODULUS; r++) begin : g_row
    for (genvar c = 0; c <= r; c++) begin : g_col
      assign tbl[tri_base(r) + c] = W'(mod_product(r, c, MODULUS));
    end
  end

  // indices past the table come only from out-of-contract operands
  always_comb begin
    if (idx_i < XW'(ENTRIES)) prod_o = tbl[idx_i[IW-1:0]];
    else                      prod_o = '0;
  end
endmodule

// File: rtl/modprod_lut.sv
`timescale 1ns/1ps
module modprod_lut #(
  parameter int MODULUS = 33,
  parameter bit OUT_REG = 1'b1,
  parameter int W       = $clog2(MODULUS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  localparam int XW = 2 * W + 1;

  logic [W-1:0]  lo;
  logic [W-1:0]  hi;
  logic [XW-1:0] idx;
  logic [W-1:0]  prod;

  modprod_order #(.W(W)) u_order (
    .x_i (a_i),
    .y_i (b_i),
    .lo_o(lo),
    .hi_o(hi)
  );

  modprod_tri_idx #(.W(W), .XW(XW)) u_idx (
    .lo_i (lo),
    .hi_i (hi),
    .idx_o(idx)
  );

  modprod_rom #(.MODULUS(MODULUS), .W(W), .XW(XW)) u_rom (
    .idx_i (idx),
    .prod_o(prod)
  );

  if (OUT_REG) begin : g_reg
    logic [W-1:0] p_d;
    logic [W-1:0] p_q;

    always_comb begin
      p_d = en ? prod : p_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p_q <= '0;
      else        p_q <= p_d;
    end

    assign p_o = p_q;
  end else begin : g_comb
    assign p_o = prod;
  end
endmodule

// File: rtl/modprod_lut_chk.sv
`timescale 1ns/1ps
module modprod_lut_chk #(
  parameter int MODULUS = 33,
  parameter bit OUT_REG = 1'b1,
  parameter int W       = $clog2(MODULUS)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] p_o
);
  // arithmetic reference, independent of the table
  logic [W-1:0] ref_p;
  assign ref_p = W'((32'(a_i) * 32'(b_i)) % 32'(MODULUS));

  p_operand_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(a_i) < 32'(MODULUS)) && (32'(b_i) < 32'(MODULUS)));

  p_result_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(p_o) < 32'(MODULUS));

  if (OUT_REG) begin : g_reg_chk
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (p_o == $past(ref_p)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(p_o));

    p_reset_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (p_o == '0));
  end else begin : g_comb_chk
    p_comb_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
      p_o == ref_p);
  end
endmodule

bind modprod_lut modprod_lut_chk #(.MODULUS(MODULUS), .OUT_REG(OUT_REG)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .en   (en),
  .a_i  (a_i),
  .b_i  (b_i),
  .p_o  (p_o)
);

// File: tb/modprod_lut_tb.sv
`timescale 1ns/1ps
module modprod_lut_tb;
  localparam int M  = 33;
  localparam int W  = $clog2(M);
  localparam int M8 = 8;
  localparam int M9 = 9;

  logic clk;
  logic rst_n;
  logic en;
  logic [W-1:0] a, b;
  logic [W-1:0] p;
  logic [2:0] a8, b8, p8;
  logic [3:0] a9, b9, p9;

  int checks;
  int errors;
  bit done;
  int res [M][M];

  modprod_lut #(.MODULUS(M), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .a_i(a), .b_i(b), .p_o(p));

  modprod_lut #(.MODULUS(M8), .OUT_REG(1'b0)) u_m8 (
    .clk(clk), .rst_n(rst_n), .en(en), .a_i(a8), .b_i(b8), .p_o(p8));

  modprod_lut #(.MODULUS(M9), .OUT_REG(1'b0)) u_m9 (
    .clk(clk), .rst_n(rst_n), .en(en), .a_i(a9), .b_i(b9), .p_o(p9));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int mulmod(input int x, input int y, input int m);
    return (x * y) % m;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive operands at a falling edge, then sample after the next rising edge
  task automatic load(input int x, input int y, input bit e);
    @(negedge clk);
    a  = W'(x);
    b  = W'(y);
    en = e;
    @(posedge clk);
    #1;
  endtask

  initial begin
    int last;
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    en     = 1'b0;
    a = '0; b = '0;
    a8 = '0; b8 = '0; a9 = '0; b9 = '0;
    void'($urandom(32'd20240611));

    // R5: output cleared while reset is held
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset value", int'(p), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R2: full operand square of the default modulus
    for (int x = 0; x < M; x++) begin
      for (int y = 0; y < M; y++) begin
        load(x, y, 1'b1);
        res[x][y] = int'(p);
        check("R1 product", int'(p), mulmod(x, y, M));
      end
    end
    for (int x = 0; x < M; x++) begin
      for (int y = x + 1; y < M; y++) begin
        check("R2 commutes", res[x][y], res[y][x]);
      end
    end

    // R6: boundary operands
    load(0, M - 1, 1'b1);
    check("R6 zero operand", int'(p), 0);
    load(M - 1, M - 1, 1'b1);
    check("R6 top squared", int'(p), 1);

    // R3: old value until the edge, new value after it
    load(5, 7, 1'b1);
    check("R3 first load", int'(p), 2);
    @(negedge clk);
    a = W'(20); b = W'(3); en = 1'b1;
    #1;
    check("R3 before edge", int'(p), 2);
    @(posedge clk);
    #1;
    check("R3 after edge", int'(p), 27);

    // R4: enable low keeps the value
    load(10, 10, 1'b0);
    check("R4 hold", int'(p), 27);
    load(32, 2, 1'b0);
    check("R4 hold again", int'(p), 27);

    // random pairs with random enable gaps
    last = 27;
    for (int i = 0; i < 2000; i++) begin
      int x, y;
      bit e;
      x = int'($urandom_range(M - 1, 0));
      y = int'($urandom_range(M - 1, 0));
      e = ($urandom_range(3, 0) != 0);
      load(x, y, e);
      if (e) last = mulmod(x, y, M);
      check(e ? "R1 random" : "R4 random hold", int'(p), last);
    end

    // R5: asynchronous clear between edges
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R5 async clear", int'(p), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: combinational variants, directed then exhaustive
    @(negedge clk);
    a8 = 3'd6; b8 = 3'd2; a9 = 4'd7; b9 = 4'd8;
    #1;
    check("R8 mod8 6*2", int'(p8), 4);
    check("R8 mod9 7*8", int'(p9), 2);
    @(negedge clk);
    a8 = 3'd4; b8 = 3'd2; a9 = 4'd8; b9 = 4'd6;
    #1;
    check("R8 mod8 4*2", int'(p8), 0);
    check("R8 mod9 8*6", int'(p9), 3);
    for (int x = 0; x < M9; x++) begin
      for (int y = 0; y < M9; y++) begin
        @(negedge clk);
        a9 = 4'(x); b9 = 4'(y);
        a8 = 3'(x % M8); b8 = 3'(y % M8);
        #1;
        check("R8 mod9 sweep", int'(p9), mulmod(x, y, M9));
        check("R8 mod8 sweep", int'(p8), mulmod(x % M8, y % M8, M8));
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule